// File: doc/BRIEF.md
# SD Host Power Control Sequencer

This block holds the power state of an SD/MMC host and decides what the card-facing pins do in each state. Software writes a single control word. A 2-bit state field in that word selects power off, power cycle or power on. The block tracks the resulting state and reports it on readback. While the card is being power cycled, it pulls the card clock, the command line and every data line low, so that the card cannot draw supply current through its signal pins. While the host is off, it drives the same pins high.

On entry to the on state the block starts a card clock from the system clock. It holds the rest of the host disabled, with command and data lines parked high, until a fixed number of card clock rising edges has gone by. After that it raises a ready output and passes the host's own command and data drive through to the pins. Three further bits of the same control word are stored and brought out as plain levels: a voltage-switch request, a voltage-switch enable, and the polarity of the external direction signals.

The state machine has four states. OFF is the reset state and reads back as field 00. CYCLE reads back as 10. WAIT is the hold-off phase and READY is normal operation; both read back as 11. The transitions are:

- from any state to OFF on a write of 00;
- from any state to CYCLE on a write of 10;
- from OFF or CYCLE to WAIT on a write of 11;
- from WAIT to READY when the hold-off count completes.

A write of 11 while in WAIT or READY changes nothing. A write of 01 changes no state.

Top module: `sd_pwr_seq`

## Requirements
- R1: After reset the readback word is 0, host_ready is 0, the three auxiliary outputs are 0, and pad_clk_o, pad_cmd_o and every pad_dat_o bit are 1 with all output enables 1.
- R2: The state field is reg_wdata[1:0] with 00 = off, 10 = cycle and 11 = on. The new state shows in reg_rdata[1:0] in the cycle after the write.
- R3: A write whose field is 01 leaves the state and reg_rdata[1:0] unchanged. It still updates the auxiliary bits.
- R4: In the cycle state, pad_clk_o, pad_cmd_o and all pad_dat_o bits are 0, with pad_cmd_oe and all pad_dat_oe bits 1.
- R5: In the off state, pad_cmd_o and all pad_dat_o bits are 1 with their enables 1, and host_ready is 0.
- R6: After a write of 11 from off or cycle, host_ready stays 0 until the HOLD_CYC-th rising edge of pad_clk_o (74 by default). It is 1 in the same cycle that edge becomes visible.
- R7: During the hold-off, pad_clk_o toggles every CLK_HALF system clocks counted from the write, and the command and data pins are driven high with their enables 1.
- R8: While host_ready is 1, pad_cmd_o/pad_cmd_oe and pad_dat_o/pad_dat_oe equal host_cmd_o/host_cmd_oe and host_dat_o/host_dat_oe.
- R9: A write of 11 while already on does not restart the hold-off, and host_ready stays 1.
- R10: A write of 00 or 10 makes host_ready 0 in the following cycle.
- R11: Bits 2, 3 and 4 of every write appear on vsw_req_o, vsw_en_o and dir_pol_o and at the same positions of reg_rdata in the next cycle.
- R12: The card clock is held at 0 in the cycle state and at 1 in the off state. It toggles only in the on state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Write strobe for the control word |
| reg_wdata | input | REG_W | Control word write data |
| reg_rdata | output | REG_W | Control word readback |
| host_cmd_o | input | 1 | Command level from the host core |
| host_cmd_oe | input | 1 | Command drive enable from the host core |
| host_dat_o | input | DAT_W | Data levels from the host core |
| host_dat_oe | input | DAT_W | Data drive enables from the host core |
| pad_clk_o | output | 1 | Card clock pin |
| pad_cmd_o | output | 1 | Command pin level |
| pad_cmd_oe | output | 1 | Command pin drive enable |
| pad_dat_o | output | DAT_W | Data pin levels |
| pad_dat_oe | output | DAT_W | Data pin drive enables |
| host_ready | output | 1 | Host enabled after the hold-off |
| vsw_req_o | output | 1 | Voltage-switch request bit |
| vsw_en_o | output | 1 | Voltage-switch enable bit |
| dir_pol_o | output | 1 | Direction-signal polarity bit |

## Verification
The bench counts card clock rising edges at the pin from both starting states. Starting from off, the clock starts at 1; starting from cycle, it starts at 0. A counter that included the initial level, or that was off by one, would raise ready one edge early or late. It checks that the reserved code 01 freezes the state both in the middle of a hold-off and in the ready state. A decoder that treated 01 as off or on would move the pins or drop ready. It rewrites 11 while ready, where a design that restarted the hold-off would drop ready. It also leaves the on state by both exits and checks that ready falls on the next cycle with the pins at the correct forced level.

// File: rtl/sdpwr_pkg.sv
`timescale 1ns/1ps
package sdpwr_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_CYCLE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_READY = 2'd3
    } pwr_state_e;

    localparam logic [1:0] FLD_OFF   = 2'b00;
    localparam logic [1:0] FLD_RSVD  = 2'b01;
    localparam logic [1:0] FLD_CYCLE = 2'b10;
    localparam logic [1:0] FLD_ON    = 2'b11;

    localparam int BIT_VSW_REQ = 2;
    localparam int BIT_VSW_EN  = 3;
    localparam int BIT_DIR_POL = 4;
    localparam int CTRL_BITS   = 5;
endpackage

// File: rtl/sdpwr_fsm.sv
`timescale 1ns/1ps
module sdpwr_fsm
    import sdpwr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [CTRL_BITS-1:0] wdata,
    input  logic                 hold_done,
    output pwr_state_e           state_o,
    output logic [1:0]           field_o,
    output logic                 on_o,
    output logic                 pass_o,
    output logic                 line_lvl_o,
    output logic                 vsw_req_o,
    output logic                 vsw_en_o,
    output logic                 dir_pol_o
);
    pwr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: if (hold_done) state_d = ST_READY;
            default: ;
        endcase
        if (we) begin
            unique case (wdata[1:0])
                FLD_OFF:   state_d = ST_OFF;
                FLD_CYCLE: state_d = ST_CYCLE;
                FLD_ON: begin
                    if (state_q == ST_OFF || state_q == ST_CYCLE)
                        state_d = ST_WAIT;
                end
                FLD_RSVD:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_OFF: begin
                field_o = FLD_OFF;   on_o = 1'b0; pass_o = 1'b0; line_lvl_o = 1'b1;
            end
            ST_CYCLE: begin
                field_o = FLD_CYCLE; on_o = 1'b0; pass_o = 1'b0; line_lvl_o = 1'b0;
            end
            ST_WAIT: begin
                field_o = FLD_ON;    on_o = 1'b1; pass_o = 1'b0; line_lvl_o = 1'b1;
            end
            ST_READY: begin
                field_o = FLD_ON;    on_o = 1'b1; pass_o = 1'b1; line_lvl_o = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vsw_req_o <= 1'b0;
            vsw_en_o  <= 1'b0;
            dir_pol_o <= 1'b0;
        end else if (we) begin
            vsw_req_o <= wdata[BIT_VSW_REQ];
            vsw_en_o  <= wdata[BIT_VSW_EN];
            dir_pol_o <= wdata[BIT_DIR_POL];
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/sdpwr_clkgen.sv
`timescale 1ns/1ps
module sdpwr_clkgen #(
    parameter int CLK_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic idle_lvl,
    output logic card_clk_o,
    output logic rise_o
);
    localparam int CW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_HALF - 1);

    logic [CW-1:0] div_q;
    logic          clk_q;
    logic          tick;

    assign tick   = run && (div_q == LAST);
    assign rise_o = tick && !clk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            clk_q <= 1'b1;
        end else if (!run) begin
            div_q <= '0;
            clk_q <= idle_lvl;
        end else if (tick) begin
            div_q <= '0;
            clk_q <= !clk_q;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign card_clk_o = run ? clk_q : idle_lvl;
endmodule

// File: rtl/sdpwr_holdoff.sv
`timescale 1ns/1ps
module sdpwr_holdoff #(
    parameter int HOLD_CYC = 74
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic rise,
    output logic done_o
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (!run)          cnt_q <= '0;
        else if (rise && !done_o) cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = run && rise && (cnt_q == LAST);
endmodule

// File: rtl/sdpwr_padmux.sv
`timescale 1ns/1ps
module sdpwr_padmux #(
    parameter int DAT_W = 8
) (
    input  logic             pass,
    input  logic             lvl,
    input  logic             host_cmd_o,
    input  logic             host_cmd_oe,
    input  logic [DAT_W-1:0] host_dat_o,
    input  logic [DAT_W-1:0] host_dat_oe,
    output logic             pad_cmd_o,
    output logic             pad_cmd_oe,
    output logic [DAT_W-1:0] pad_dat_o,
    output logic [DAT_W-1:0] pad_dat_oe
);
    assign pad_cmd_o  = pass ? host_cmd_o  : lvl;
    assign pad_cmd_oe = pass ? host_cmd_oe : 1'b1;

    for (genvar i = 0; i < DAT_W; i++) begin : g_lane
        assign pad_dat_o[i]  = pass ? host_dat_o[i]  : lvl;
        assign pad_dat_oe[i] = pass ? host_dat_oe[i] : 1'b1;
    end
endmodule

// File: rtl/sd_pwr_seq.sv
`timescale 1ns/1ps
module sd_pwr_seq
    import sdpwr_pkg::*;
#(
    parameter int REG_W    = 32,
    parameter int DAT_W    = 8,
    parameter int CLK_HALF = 2,
    parameter int HOLD_CYC = 74
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             host_cmd_o,
    input  logic             host_cmd_oe,
    input  logic [DAT_W-1:0] host_dat_o,
    input  logic [DAT_W-1:0] host_dat_oe,
    output logic             pad_clk_o,
    output logic             pad_cmd_o,
    output logic             pad_cmd_oe,
    output logic [DAT_W-1:0] pad_dat_o,
    output logic [DAT_W-1:0] pad_dat_oe,
    output logic             host_ready,
    output logic             vsw_req_o,
    output logic             vsw_en_o,
    output logic             dir_pol_o
);
    pwr_state_e state;
    logic [1:0] field;
    logic       on, pass, line_lvl, rise, hold_done;
    logic       unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[REG_W-1:CTRL_BITS];

    sdpwr_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (reg_we),
        .wdata      (reg_wdata[CTRL_BITS-1:0]),
        .hold_done  (hold_done),
        .state_o    (state),
        .field_o    (field),
        .on_o       (on),
        .pass_o     (pass),
        .line_lvl_o (line_lvl),
        .vsw_req_o  (vsw_req_o),
        .vsw_en_o   (vsw_en_o),
        .dir_pol_o  (dir_pol_o)
    );

    sdpwr_clkgen #(.CLK_HALF(CLK_HALF)) u_clk (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (on),
        .idle_lvl   (line_lvl),
        .card_clk_o (pad_clk_o),
        .rise_o     (rise)
    );

    sdpwr_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == ST_WAIT),
        .rise   (rise),
        .done_o (hold_done)
    );

    sdpwr_padmux #(.DAT_W(DAT_W)) u_pad (
        .pass        (pass),
        .lvl         (line_lvl),
        .host_cmd_o  (host_cmd_o),
        .host_cmd_oe (host_cmd_oe),
        .host_dat_o  (host_dat_o),
        .host_dat_oe (host_dat_oe),
        .pad_cmd_o   (pad_cmd_o),
        .pad_cmd_oe  (pad_cmd_oe),
        .pad_dat_o   (pad_dat_o),
        .pad_dat_oe  (pad_dat_oe)
    );

    assign host_ready = pass;

    always_comb begin
        reg_rdata              = '0;
        reg_rdata[1:0]         = field;
        reg_rdata[BIT_VSW_REQ] = vsw_req_o;
        reg_rdata[BIT_VSW_EN]  = vsw_en_o;
        reg_rdata[BIT_DIR_POL] = dir_pol_o;
    end
endmodule

// File: rtl/sdpwr_chk.sv
`timescale 1ns/1ps
module sdpwr_chk #(
    parameter int REG_W    = 32,
    parameter int DAT_W    = 8,
    parameter int HOLD_CYC = 74
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             pad_clk_o,
    input logic             pad_cmd_o,
    input logic             pad_cmd_oe,
    input logic [DAT_W-1:0] pad_dat_o,
    input logic [DAT_W-1:0] pad_dat_oe,
    input logic             host_ready,
    input logic             vsw_req_o,
    input logic             vsw_en_o,
    input logic             dir_pol_o
);
    localparam int CW = $clog2(HOLD_CYC + 2);

    logic          prev_clk;
    logic [CW-1:0] rise_cnt;
    logic          on_now;
    logic          rise_now;

    assign on_now   = (reg_rdata[1:0] == 2'b11);
    assign rise_now = pad_clk_o && !prev_clk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_clk <= 1'b1;
            rise_cnt <= '0;
        end else begin
            prev_clk <= pad_clk_o;
            if (!on_now)
                rise_cnt <= '0;
            else if (rise_now && !host_ready)
                rise_cnt <= rise_cnt + 1'b1;
        end
    end

    // R4
    cycle_lines_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[1:0] == 2'b10) |-> (!pad_clk_o && !pad_cmd_o && pad_cmd_oe
                                       && pad_dat_o == '0 && &pad_dat_oe));
    // R5
    off_lines_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[1:0] == 2'b00) |-> (pad_clk_o && pad_cmd_o && pad_cmd_oe
                                       && &pad_dat_o && &pad_dat_oe && !host_ready));
    // R3
    rsvd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_wdata[1:0] == 2'b01) |=> (reg_rdata[1:0] == $past(reg_rdata[1:0])));
    // R10
    leave_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !reg_wdata[0]) |=> !host_ready);
    // R6
    hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_ready) |-> ((rise_cnt + CW'(rise_now)) == CW'(HOLD_CYC)));
    // R6
    ready_only_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> on_now);
    // R9
    reon_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ready && reg_we && reg_wdata[1:0] == 2'b11) |=> host_ready);
    // R11
    aux_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (vsw_req_o == $past(reg_wdata[2]) && vsw_en_o == $past(reg_wdata[3])
                    && dir_pol_o == $past(reg_wdata[4])));
endmodule

bind sd_pwr_seq sdpwr_chk #(.REG_W(REG_W), .DAT_W(DAT_W), .HOLD_CYC(HOLD_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .pad_clk_o  (pad_clk_o),
    .pad_cmd_o  (pad_cmd_o),
    .pad_cmd_oe (pad_cmd_oe),
    .pad_dat_o  (pad_dat_o),
    .pad_dat_oe (pad_dat_oe),
    .host_ready (host_ready),
    .vsw_req_o  (vsw_req_o),
    .vsw_en_o   (vsw_en_o),
    .dir_pol_o  (dir_pol_o)
);

// File: tb/tb_sd_pwr_seq.sv
`timescale 1ns/1ps
module tb_sd_pwr_seq;
    localparam int REG_W = 32;
    localparam int DAT_W = 8;
    localparam int HALF  = 2;
    localparam int HOLD  = 74;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_we = 1'b0;
    logic [REG_W-1:0] reg_wdata = '0;
    logic [REG_W-1:0] reg_rdata;
    logic             host_cmd_o = 1'b0;
    logic             host_cmd_oe = 1'b0;
    logic [DAT_W-1:0] host_dat_o = 8'h5A;
    logic [DAT_W-1:0] host_dat_oe = 8'h0F;
    logic             pad_clk_o, pad_cmd_o, pad_cmd_oe;
    logic [DAT_W-1:0] pad_dat_o, pad_dat_oe;
    logic             host_ready, vsw_req_o, vsw_en_o, dir_pol_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sd_pwr_seq #(.REG_W(REG_W), .DAT_W(DAT_W), .CLK_HALF(HALF), .HOLD_CYC(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .host_cmd_o(host_cmd_o), .host_cmd_oe(host_cmd_oe),
        .host_dat_o(host_dat_o), .host_dat_oe(host_dat_oe), .pad_clk_o(pad_clk_o),
        .pad_cmd_o(pad_cmd_o), .pad_cmd_oe(pad_cmd_oe), .pad_dat_o(pad_dat_o),
        .pad_dat_oe(pad_dat_oe), .host_ready(host_ready), .vsw_req_o(vsw_req_o),
        .vsw_en_o(vsw_en_o), .dir_pol_o(dir_pol_o)
    );

    // {wdata[4:0], expected field[1:0], check clock, expected clock, expected line level}
    localparam logic [9:0] VEC [8] = '{
        {5'b00010, 2'b10, 1'b1, 1'b0, 1'b0},
        {5'b11100, 2'b00, 1'b1, 1'b1, 1'b1},
        {5'b00001, 2'b00, 1'b1, 1'b1, 1'b1},
        {5'b01010, 2'b10, 1'b1, 1'b0, 1'b0},
        {5'b10001, 2'b10, 1'b1, 1'b0, 1'b0},
        {5'b00011, 2'b11, 1'b1, 1'b0, 1'b1},
        {5'b00001, 2'b11, 1'b0, 1'b0, 1'b1},
        {5'b00000, 2'b00, 1'b1, 1'b1, 1'b1}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] v);
        reg_we    = 1'b1;
        reg_wdata = {27'd0, v};
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic check_lines(input logic lvl, input string req);
        check(pad_cmd_o == lvl && pad_cmd_oe, req, {pad_cmd_oe, pad_cmd_o}, {1'b1, lvl});
        check(pad_dat_o == {DAT_W{lvl}} && pad_dat_oe == '1, req,
              {pad_dat_oe, pad_dat_o}, {8'hFF, {DAT_W{lvl}}});
    endtask

    task automatic run_holdoff(input string tag);
        logic prev, cur;
        int   s = 0, last = 0, rises = 0, bad_ivl = 0, bad_line = 0;
        bit   got = 0;
        prev = pad_clk_o;
        wr(5'b00011);
        while (!got && s < 5000) begin
            cur = pad_clk_o;
            if (cur != prev) begin
                if (s - last != HALF) bad_ivl++;
                last = s;
                if (cur && !prev) rises++;
            end
            prev = cur;
            if (host_ready) got = 1;
            else begin
                if (!(pad_cmd_o && pad_cmd_oe && &pad_dat_o && &pad_dat_oe)) bad_line++;
                @(negedge clk);
                s++;
            end
        end
        // R6 ready appears exactly at the HOLD-th rising card clock edge
        check(got && rises == HOLD, {"R6 ", tag}, rises, HOLD);
        // R7 half period and parked-high lines during hold-off
        check(bad_ivl == 0, {"R7 interval ", tag}, bad_ivl, 0);
        check(bad_line == 0, {"R7 lines ", tag}, bad_line, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(reg_rdata == '0 && !host_ready, "R1 readback/ready", {host_ready, reg_rdata[30:0]}, 0);
        check({vsw_req_o, vsw_en_o, dir_pol_o} == 3'b000, "R1 aux", {vsw_req_o, vsw_en_o, dir_pol_o}, 0);
        check(pad_clk_o == 1'b1, "R1 clock", pad_clk_o, 1);
        check_lines(1'b1, "R1 lines");

        foreach (VEC[i]) begin
            logic [4:0] wd;
            string      tag;
            wd = VEC[i][9:5];
            wr(wd);
            tag = (wd[1:0] == 2'b01) ? "R3" : "R2";
            check(reg_rdata[1:0] == VEC[i][4:3], {tag, " field"}, reg_rdata[1:0], VEC[i][4:3]);
            // R11 aux bits follow every write, reserved code included
            check({dir_pol_o, vsw_en_o, vsw_req_o} == wd[4:2] && reg_rdata[4:2] == wd[4:2],
                  "R11 aux", {dir_pol_o, vsw_en_o, vsw_req_o}, wd[4:2]);
            if (VEC[i][2])
                check(pad_clk_o == VEC[i][1], "R12 clock gate", pad_clk_o, VEC[i][1]);
            check_lines(VEC[i][0], (VEC[i][4:3] == 2'b10) ? "R4" :
                                   (VEC[i][4:3] == 2'b00) ? "R5" : "R7");
            check(!host_ready, "R10 ready low", host_ready, 0);
        end

        // R6 from off (clock idle high)
        run_holdoff("from off");

        // R8 pass-through with two host patterns
        host_cmd_o = 1'b1; host_cmd_oe = 1'b0; host_dat_o = 8'hC3; host_dat_oe = 8'hA5;
        #1;
        check(pad_cmd_o == 1'b1 && pad_cmd_oe == 1'b0 && pad_dat_o == 8'hC3 && pad_dat_oe == 8'hA5,
              "R8 pass A", {pad_cmd_oe, pad_cmd_o, pad_dat_oe, pad_dat_o}, {2'b01, 16'hA5C3});
        host_cmd_o = 1'b0; host_cmd_oe = 1'b1; host_dat_o = 8'h3C; host_dat_oe = 8'h5A;
        #1;
        check(pad_cmd_o == 1'b0 && pad_cmd_oe == 1'b1 && pad_dat_o == 8'h3C && pad_dat_oe == 8'h5A,
              "R8 pass B", {pad_cmd_oe, pad_cmd_o, pad_dat_oe, pad_dat_o}, {2'b10, 16'h5A3C});
        @(negedge clk);

        // R9 rewrite on keeps ready
        wr(5'b00011);
        check(host_ready, "R9 re-on", host_ready, 1);
        repeat (3) @(negedge clk);
        check(host_ready, "R9 re-on later", host_ready, 1);

        // R3 reserved code while ready
        wr(5'b00001);
        check(host_ready && reg_rdata[1:0] == 2'b11, "R3 reserved in ready",
              {host_ready, reg_rdata[1:0]}, 3'b111);

        // R10 leave via cycle, R12 clock low
        wr(5'b00010);
        check(!host_ready, "R10 exit to cycle", host_ready, 0);
        check(pad_clk_o == 1'b0, "R12 cycle clock", pad_clk_o, 0);
        check_lines(1'b0, "R4 after ready");

        // R6 from cycle (clock idle low)
        run_holdoff("from cycle");

        // R10 leave via off, R5 lines high
        wr(5'b00000);
        check(!host_ready, "R10 exit to off", host_ready, 0);
        check(pad_clk_o == 1'b1, "R12 off clock", pad_clk_o, 1);
        check_lines(1'b1, "R5 after ready");
        repeat (5) @(negedge clk);
        check(pad_clk_o == 1'b1, "R12 off stays", pad_clk_o, 1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule